// File: doc/BRIEF.md
# Host Control Register with Request Steering

This block holds the host-side control word of a DSP host port and turns a pending transmit-data-request flag into either an interrupt request or a DMA request. The host reaches the register over one of two paths. The first is a PCI-style memory-mapped target, where the register sits at a fixed offset inside the block's window. The second is a simpler universal bus, where the upper address bits are compared against a programmed base field.

A write is merged byte lane by byte lane into a shadow copy. The merged value becomes the active control word only when the single-cycle transaction-complete strobe arrives, so the request outputs never change partway through a transaction.

The active word holds two control bits. Transmit-enable sits at bit 1 and DMA-enable at bit 17. They choose which request line carries the transmit-data-request, and the line that is not chosen is held quiet. When the DMA path is chosen and the interrupt-drive input is low, the interrupt output is released to high impedance rather than driven inactive. Steering applies only in the universal-bus modes. In PCI mode, and in the idle mode, neither request output is enabled.

Top module: `hcsTop`

## Requirements
- R1: With busMode = 1 (PCI), the register is selected only when memSpace is 1 and addr equals 0x010. Any write with memSpace = 0 or a different address leaves the register unchanged.
- R2: With busMode = 2 or 3 (universal bus), the register is selected only when addr[10:3] equals baseField and addr[2:0] equals 4. Writes to other addresses leave the register unchanged.
- R3: byteEn[k] gates wrData[8k+7:8k]. A lane whose enable is 0 keeps its previous contents.
- R4: A write changes neither rdData nor the request outputs until the cycle after xferDone is high. A write issued in the same cycle as xferDone is included in that commit.
- R5: Reset clears both control bits, so the register reads 0 after reset.
- R6: In a universal-bus mode with DMA-enable (bit 17) = 0, irqN is low and irqOe is 1 exactly when transmit-enable (bit 1) and txReqStatus are both 1. In this case dmaReq is 0.
- R7: In a universal-bus mode with DMA-enable = 1, dmaReq equals transmit-enable AND txReqStatus, and irqN is high. The interrupt line is driven (irqOe = 1) when irqDrive = 1.
- R8: In a universal-bus mode with DMA-enable = 1 and irqDrive = 0, irqOe is 0 (high impedance).
- R9: With busMode = 0 or 1, irqOe and dmaOe are both 0, irqN is 1 and dmaReq is 0.
- R10: A selected read returns the active word with all bits other than 1 and 17 as zero. rdData is 0 whenever rdEn is low or the register is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busMode | input | 2 | 0 idle, 1 PCI, 2/3 universal bus |
| memSpace | input | 1 | PCI transaction targets memory space |
| baseField | input | 8 | Programmed base for universal-bus decode |
| addr | input | 11 | Address or window offset |
| wrEn | input | 1 | Write data phase |
| rdEn | input | 1 | Read data phase |
| byteEn | input | 4 | Byte-lane enables |
| wrData | input | 32 | Write data |
| xferDone | input | 1 | Single-cycle transaction-complete strobe |
| rdData | output | 32 | Read data |
| txReqStatus | input | 1 | Transmit-data-request status |
| irqDrive | input | 1 | Interrupt line drive control |
| irqN | output | 1 | Interrupt request, active low |
| irqOe | output | 1 | Interrupt line output enable |
| dmaReq | output | 1 | DMA request, active high |
| dmaOe | output | 1 | DMA request output enable |

## Verification
The case that matters most is a data write that lands in the same cycle as the transaction-complete strobe. Here the lane merge and the commit both act at one edge, and the merged word must reach the active register without losing the lanes that were not written. The bench provokes this by writing only the DMA-enable lane with xferDone high. It then reads the word back and checks that the new lane and the transmit-enable bit kept from the earlier write are both present. It also watches that the request outputs move only after the strobe.

// File: rtl/hcsPkg.sv
package hcsPkg;
  typedef struct packed {
    logic wr;
    logic rd;
    logic commit;
  } hcsStrobes_t;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_PCI  = 2'd1,
    MODE_UB0  = 2'd2,
    MODE_UB1  = 2'd3
  } hcsMode_e;
endpackage

// File: rtl/hcsCtl.sv
module hcsCtl import hcsPkg::*; #(
  parameter int ADDR_W = 11,
  parameter int BASE_W = 8,
  parameter int PCI_OFFSET = 16,
  parameter int UB_SUB = 4
) (
  input  logic [1:0]        busMode,
  input  logic              memSpace,
  input  logic [BASE_W-1:0] baseField,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              xferDone,
  output hcsStrobes_t       strobes,
  output logic              ubMode
);
  localparam int SUB_W = ADDR_W - BASE_W;

  logic pciHit;
  logic ubHit;
  logic sel;

  always_comb begin
    ubMode = (busMode == MODE_UB0) || (busMode == MODE_UB1);
    pciHit = (busMode == MODE_PCI) && memSpace &&
             (addr == ADDR_W'(PCI_OFFSET));
    ubHit  = ubMode && (addr[ADDR_W-1:SUB_W] == baseField) &&
             (addr[SUB_W-1:0] == SUB_W'(UB_SUB));
    sel    = pciHit || ubHit;
    strobes.wr     = sel && wrEn;
    strobes.rd     = sel && rdEn;
    strobes.commit = xferDone;
  end
endmodule

// File: rtl/hcsDp.sv
module hcsDp import hcsPkg::*; #(
  parameter int DATA_W = 32,
  parameter int TX_EN_BIT = 1,
  parameter int DMA_EN_BIT = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  hcsStrobes_t       strobes,
  input  logic [DATA_W/8-1:0] byteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txEn,
  output logic              dmaEn
);
  localparam int LANES = DATA_W / 8;
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << TX_EN_BIT) | (DATA_W'(1) << DMA_EN_BIT);

  logic [DATA_W-1:0] shadowQ;
  logic [DATA_W-1:0] activeQ;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] shadowNext;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign merged[8*g +: 8] = byteEn[g] ? wrData[8*g +: 8] : shadowQ[8*g +: 8];
  end

  assign shadowNext = (strobes.wr ? merged : shadowQ) & IMPL_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      activeQ <= '0;
    end else begin
      shadowQ <= shadowNext;
      if (strobes.commit) activeQ <= shadowNext;
    end
  end

  assign rdData = strobes.rd ? activeQ : '0;
  assign txEn   = activeQ[TX_EN_BIT];
  assign dmaEn  = activeQ[DMA_EN_BIT];
endmodule

// File: rtl/hcsSteer.sv
module hcsSteer (
  input  logic ubMode,
  input  logic txEn,
  input  logic dmaEn,
  input  logic txReqStatus,
  input  logic irqDrive,
  output logic irqN,
  output logic irqOe,
  output logic dmaReq,
  output logic dmaOe
);
  logic pend;

  always_comb begin
    pend   = txEn && txReqStatus;
    irqN   = 1'b1;
    irqOe  = 1'b0;
    dmaReq = 1'b0;
    dmaOe  = 1'b0;
    if (ubMode) begin
      dmaOe = 1'b1;
      if (dmaEn) begin
        dmaReq = pend;
        irqOe  = irqDrive;
      end else begin
        irqN  = !pend;
        irqOe = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hcsTop.sv
module hcsTop import hcsPkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11,
  parameter int BASE_W = 8,
  parameter int PCI_OFFSET = 16,
  parameter int UB_SUB = 4,
  parameter int TX_EN_BIT = 1,
  parameter int DMA_EN_BIT = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busMode,
  input  logic              memSpace,
  input  logic [BASE_W-1:0] baseField,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W/8-1:0] byteEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              xferDone,
  output logic [DATA_W-1:0] rdData,
  input  logic              txReqStatus,
  input  logic              irqDrive,
  output logic              irqN,
  output logic              irqOe,
  output logic              dmaReq,
  output logic              dmaOe
);
  hcsStrobes_t strobes;
  logic ubMode;
  logic txEn;
  logic dmaEn;

  hcsCtl #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .PCI_OFFSET(PCI_OFFSET),
           .UB_SUB(UB_SUB)) uCtl (
    .busMode(busMode), .memSpace(memSpace), .baseField(baseField),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .xferDone(xferDone),
    .strobes(strobes), .ubMode(ubMode)
  );

  hcsDp #(.DATA_W(DATA_W), .TX_EN_BIT(TX_EN_BIT),
          .DMA_EN_BIT(DMA_EN_BIT)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .txEn(txEn), .dmaEn(dmaEn)
  );

  hcsSteer uSteer (
    .ubMode(ubMode), .txEn(txEn), .dmaEn(dmaEn), .txReqStatus(txReqStatus),
    .irqDrive(irqDrive), .irqN(irqN), .irqOe(irqOe), .dmaReq(dmaReq),
    .dmaOe(dmaOe)
  );
endmodule

// File: rtl/hcsChk.sv
module hcsChk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busMode,
  input logic              txReqStatus,
  input logic              irqDrive,
  input logic              xferDone,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              irqN,
  input logic              irqOe,
  input logic              dmaReq,
  input logic              dmaOe
);
  AST_PCI_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (busMode < 2'd2) |-> (!irqOe && !dmaOe && irqN && !dmaReq)); // R9

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaReq && !irqN)); // R6

  AST_DMA_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (irqN && dmaOe)); // R7

  AST_DMA_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (busMode[1] && !irqDrive && dmaReq) |-> !irqOe); // R8

  AST_NO_MIDXFER_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !xferDone |=> (($stable(txReqStatus) && $stable(busMode) && $stable(irqDrive))
                   -> ($stable(irqN) && $stable(irqOe) && $stable(dmaReq)))); // R4

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0)); // R10
endmodule

bind hcsTop hcsChk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_hcsTop.sv
`timescale 1ns/100ps
module sim_hcsTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busMode = 2'd2;
  logic memSpace = 1'b0;
  logic [7:0] baseField = 8'h5A;
  logic [10:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, xferDone = 1'b0;
  logic [3:0] byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic txReqStatus = 1'b0, irqDrive = 1'b1;
  logic irqN, irqOe, dmaReq, dmaOe;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  bit finished = 0;

  localparam logic [10:0] UB_ADDR = {8'h5A, 3'd4};

  always #2.5 clk = ~clk;

  hcsTop u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values as reads are issued
  always @(negedge clk) begin
    #1;
    if (rdEn) begin
      if (expQ.size() == 0) check("SCOREBOARD_EMPTY", 32'd1, 32'd0);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic idle();
    @(negedge clk);
    wrEn = 0; rdEn = 0; xferDone = 0;
  endtask

  task automatic wr(logic [10:0] a, logic [3:0] be, logic [31:0] d, logic done);
    @(negedge clk);
    addr = a; byteEn = be; wrData = d; wrEn = 1; rdEn = 0; xferDone = done;
    idle();
  endtask

  task automatic commit();
    @(negedge clk);
    xferDone = 1;
    idle();
  endtask

  task automatic rd(logic [10:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; wrEn = 0; rdEn = 1; xferDone = 0;
    expQ.push_back(exp); tagQ.push_back(tag);
    idle();
  endtask

  task automatic pins(string tag, logic en, logic oe, logic dr, logic doe);
    #1;
    check({tag, " irqN"}, {31'd0, irqN}, {31'd0, en});
    check({tag, " irqOe"}, {31'd0, irqOe}, {31'd0, oe});
    check({tag, " dmaReq"}, {31'd0, dmaReq}, {31'd0, dr});
    check({tag, " dmaOe"}, {31'd0, dmaOe}, {31'd0, doe});
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    rd(UB_ADDR, 32'h0, "R5 reset value");
    pins("R6 idle", 1, 1, 0, 1);

    txReqStatus = 1;
    wr(UB_ADDR, 4'b0001, 32'h0000_0002, 0);
    pins("R4 before commit", 1, 1, 0, 1);
    rd(UB_ADDR, 32'h0, "R4 read before commit");
    commit();
    rd(UB_ADDR, 32'h0000_0002, "R4 read after commit");
    pins("R6 irq asserted", 0, 1, 0, 1);

    wr(UB_ADDR, 4'b1011, 32'hFFFF_FFFF, 1);
    rd(UB_ADDR, 32'h0000_0002, "R3 R10 lane2 masked");
    wr(UB_ADDR, 4'b0100, 32'h0002_0000, 1);
    rd(UB_ADDR, 32'h0002_0002, "R3 R4 same-cycle commit");

    irqDrive = 1;
    pins("R7 dma steering", 1, 1, 1, 1);
    irqDrive = 0;
    pins("R8 irq hiz", 1, 0, 1, 1);
    txReqStatus = 0;
    pins("R7 no status", 1, 0, 0, 1);

    busMode = 2'd3;
    wr({8'h5B, 3'd4}, 4'hF, 32'h0, 1);
    wr({8'h5A, 3'd3}, 4'hF, 32'h0, 1);
    rd(UB_ADDR, 32'h0002_0002, "R2 wrong address ignored");
    rd({8'h5A, 3'd3}, 32'h0, "R10 unselected read zero");

    busMode = 2'd1;
    txReqStatus = 1;
    pins("R9 PCI no drive", 1, 0, 0, 0);
    memSpace = 0;
    wr(11'h010, 4'hF, 32'h0, 1);
    memSpace = 1;
    rd(11'h010, 32'h0002_0002, "R1 non-memory write ignored");
    wr(11'h014, 4'hF, 32'h0, 1);
    rd(11'h010, 32'h0002_0002, "R1 other offset ignored");
    wr(11'h010, 4'hF, 32'h0000_0002, 1);
    rd(11'h010, 32'h0000_0002, "R1 PCI write");
    busMode = 2'd0;
    pins("R9 idle mode", 1, 0, 0, 0);

    busMode = 2'd2;
    pins("R6 back to irq", 0, 1, 0, 1);
    #1 check("R10 rdEn low", rdData, 32'h0);

    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    rd(UB_ADDR, 32'h0, "R5 reset clears");
    pins("R5 request off", 1, 1, 0, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule